// File: doc/BRIEF.md
# Device Control and Status Register with Error Signalling

This block holds one 32-bit device control/status word in a configuration space. The word has three kinds of fields. Read/write control fields set the error-report enables, the ordering, tag and snoop permissions, and the payload and read-request limits. Some fields are hardwired to zero. Four sticky error-detected flags are cleared by writing a one to them. Software reaches the word through a simple synchronous access port: a byte address, a write strobe, four byte lanes and combinational read data. Only the configured offset (0xC8 by default) decodes.

Hardware reports error events to the block as one-cycle pulses. Internal events are correctable, uncorrectable with a severity bit, and unsupported request, each with its own mask or class inputs. Received error messages arrive the same way, in three classes. The detected flags record every internal event, masked or not. The three error-signalling outputs (correctable, non-fatal, fatal) are gated per class by the enable bits or by the SERR Enable input, and they fire only in Root Port mode. Each output is a registered pulse that appears one clock after the triggering input.

Top module: `devctl_status_reg`

## Requirements
- R1: After reset, a read at the decoded offset returns 0x00002910 while `np_pending` is low. This means bit 4, bit 8 and bit 11 are set, bits 14:12 hold 3'b010, and every other bit is 0.
- R2: A write at the decoded offset updates each writable field (bits 8:0, bit 11, bits 14:12) only in a byte lane whose `acc_be` bit is set. A write at any other address changes nothing, and a read at any other address returns zero.
- R3: Bits 9, 10, 15, 20 and 31:22 always read as zero, and writes to them have no effect.
- R4: Bit 21 of the read data follows `np_pending` in the same cycle.
- R5: Bit 16 sets on `ev_corr`. Bit 17 sets on `ev_uncor` with `ev_uncor_sev`=0. Bit 18 sets on `ev_uncor` with `ev_uncor_sev`=1. Bit 19 sets on `ev_ur`. Each flag sets whatever the mask inputs say, and received messages set no flag. Each flag is visible one cycle after its event.
- R6: Writing 1 to a flag bit, with byte lane 2 enabled, clears that flag. Writing 0 leaves it unchanged, and so does a write with lane 2 disabled. If a set and a clear of the same flag fall in one cycle, the flag ends up set.
- R7: `sig_corr` pulses when bit 0 is set and either an unmasked `ev_corr` or a `msg_corr` occurred.
- R8: `sig_nonfatal` pulses when bit 1 or `serr_en` is set and either an unmasked `ev_uncor` with severity 0 or a `msg_nonfatal` occurred.
- R9: `sig_fatal` pulses when bit 2 or `serr_en` is set and either an unmasked `ev_uncor` with severity 1 or a `msg_fatal` occurred.
- R10: An `ev_ur` with `ev_ur_uncor`=0 drives `sig_corr` if bit 3 is set. With `ev_ur_uncor`=1 it drives `sig_nonfatal` (severity 0) or `sig_fatal` (severity 1) if bit 3 is set. An uncorrectable `ev_ur` also drives `sig_fatal` whenever `serr_en` is set.
- R11: All three outputs stay low unless `root_port` was high in the cycle of the trigger. Each output is registered: it rises on the clock edge that samples its trigger and falls the cycle after the trigger goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_wr | input | 1 | Write strobe |
| acc_be | input | 4 | Byte-lane enables for the write |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_addr` (combinational) |
| root_port | input | 1 | Root Port mode |
| serr_en | input | 1 | SERR Enable from the command register |
| np_pending | input | 1 | Non-posted request outstanding |
| ev_corr | input | 1 | Internal correctable error pulse |
| ev_corr_masked | input | 1 | Correctable error is masked |
| ev_uncor | input | 1 | Internal uncorrectable error pulse |
| ev_uncor_masked | input | 1 | Uncorrectable error is masked |
| ev_uncor_sev | input | 1 | Severity of the uncorrectable error (1 = fatal) |
| ev_ur | input | 1 | Unsupported request pulse |
| ev_ur_uncor | input | 1 | Unsupported request is uncorrectable |
| ev_ur_sev | input | 1 | Severity of an uncorrectable unsupported request |
| msg_corr | input | 1 | Correctable error message received |
| msg_nonfatal | input | 1 | Non-fatal error message received |
| msg_fatal | input | 1 | Fatal error message received |
| sig_corr | output | 1 | Correctable error signal |
| sig_nonfatal | output | 1 | Non-fatal error signal |
| sig_fatal | output | 1 | Fatal error signal |

## Verification
Two functions can land in the same cycle: the hardware setting a detected flag and a software write-one-to-clear of that same flag. The bench provokes this by driving `ev_corr` in the exact cycle that carries a clear write to bit 16. It then reads the word back and passes only if the flag is still set. A second cycle-sharing case also gets a directed test. A write that changes an enable bit in the event's own cycle still gates by the old enable value. The bench expects the output pulse to follow the value the enable held before the write.

// File: rtl/devctl_pkg.sv
package devctl_pkg;
    localparam int REG_W     = 32;
    localparam int NBYTE     = REG_W / 8;
    localparam int NFLAG     = 4;

    localparam int B_COR_EN  = 0;
    localparam int B_NF_EN   = 1;
    localparam int B_FAT_EN  = 2;
    localparam int B_UR_EN   = 3;
    localparam int FLAG_LO   = 16;
    localparam int FLAG_LANE = FLAG_LO / 8;
    localparam int PEND_BIT  = 21;

    localparam logic [REG_W-1:0] CTRL_RW_MASK = 32'h0000_79FF;
    localparam logic [REG_W-1:0] CTRL_RST     = 32'h0000_2910;

    typedef enum logic [1:0] {
        FL_COR = 2'd0,
        FL_NF  = 2'd1,
        FL_FAT = 2'd2,
        FL_UR  = 2'd3
    } flag_e;

    typedef struct packed {
        logic cor;
        logic nf;
        logic fat;
    } sig_t;
endpackage

// File: rtl/devctl_ctrl_regs.sv
module devctl_ctrl_regs
    import devctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [NBYTE-1:0] be,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl_q
);
    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[b*8 +: 8] <= CTRL_RST[b*8 +: 8];
            else if (wr_hit && be[b])
                ctrl_q[b*8 +: 8] <= wdata[b*8 +: 8] & CTRL_RW_MASK[b*8 +: 8];
        end
    end
endmodule

// File: rtl/devctl_status_flags.sv
module devctl_status_flags
    import devctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    output logic [NFLAG-1:0] flag_q
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (set[i])
                flag_q[i] <= 1'b1;
            else if (clr[i])
                flag_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/devctl_err_signal.sv
module devctl_err_signal
    import devctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       rep_en,
    input  logic             root_port,
    input  logic             serr_en,
    input  logic             ev_corr,
    input  logic             ev_corr_masked,
    input  logic             ev_uncor,
    input  logic             ev_uncor_masked,
    input  logic             ev_uncor_sev,
    input  logic             ev_ur,
    input  logic             ev_ur_uncor,
    input  logic             ev_ur_sev,
    input  logic             msg_corr,
    input  logic             msg_nonfatal,
    input  logic             msg_fatal,
    output logic [NFLAG-1:0] flag_set,
    output sig_t             sig_q
);
    logic cor_hit, nf_hit, fat_hit;
    logic ur_cor, ur_nf, ur_fat;
    logic en_nf, en_fat;
    sig_t sig_d;

    always_comb begin
        flag_set         = '0;
        flag_set[FL_COR] = ev_corr;
        flag_set[FL_NF]  = ev_uncor && !ev_uncor_sev;
        flag_set[FL_FAT] = ev_uncor &&  ev_uncor_sev;
        flag_set[FL_UR]  = ev_ur;
    end

    always_comb begin
        cor_hit = (ev_corr && !ev_corr_masked) || msg_corr;
        nf_hit  = (ev_uncor && !ev_uncor_masked && !ev_uncor_sev) || msg_nonfatal;
        fat_hit = (ev_uncor && !ev_uncor_masked &&  ev_uncor_sev) || msg_fatal;
        ur_cor  = ev_ur && !ev_ur_uncor && rep_en[B_UR_EN];
        ur_nf   = ev_ur &&  ev_ur_uncor && !ev_ur_sev && rep_en[B_UR_EN];
        ur_fat  = ev_ur &&  ev_ur_uncor &&
                  ((ev_ur_sev && rep_en[B_UR_EN]) || serr_en);
        en_nf   = rep_en[B_NF_EN]  || serr_en;
        en_fat  = rep_en[B_FAT_EN] || serr_en;
        sig_d.cor = root_port && ((rep_en[B_COR_EN] && cor_hit) || ur_cor);
        sig_d.nf  = root_port && ((en_nf && nf_hit) || ur_nf);
        sig_d.fat = root_port && ((en_fat && fat_hit) || ur_fat);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sig_q <= '0;
        else
            sig_q <= sig_d;
    end
endmodule

// File: rtl/devctl_status_reg.sv
module devctl_status_reg
    import devctl_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'hC8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic [3:0]        acc_be,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    input  logic              root_port,
    input  logic              serr_en,
    input  logic              np_pending,
    input  logic              ev_corr,
    input  logic              ev_corr_masked,
    input  logic              ev_uncor,
    input  logic              ev_uncor_masked,
    input  logic              ev_uncor_sev,
    input  logic              ev_ur,
    input  logic              ev_ur_uncor,
    input  logic              ev_ur_sev,
    input  logic              msg_corr,
    input  logic              msg_nonfatal,
    input  logic              msg_fatal,
    output logic              sig_corr,
    output logic              sig_nonfatal,
    output logic              sig_fatal
);
    logic             acc_hit;
    logic             wr_hit;
    logic [REG_W-1:0] ctrl_q;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    logic [REG_W-1:0] stat_word;
    sig_t             sig_q;

    assign acc_hit  = (acc_addr == REG_OFFSET);
    assign wr_hit   = acc_hit && acc_wr;
    assign flag_clr = (wr_hit && acc_be[FLAG_LANE]) ?
                      acc_wdata[FLAG_LO +: NFLAG] : '0;

    devctl_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .be     (acc_be),
        .wdata  (acc_wdata),
        .ctrl_q (ctrl_q)
    );

    devctl_status_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (flag_set),
        .clr    (flag_clr),
        .flag_q (flag_q)
    );

    devctl_err_signal u_sig (
        .clk             (clk),
        .rst_n           (rst_n),
        .rep_en          (ctrl_q[3:0]),
        .root_port       (root_port),
        .serr_en         (serr_en),
        .ev_corr         (ev_corr),
        .ev_corr_masked  (ev_corr_masked),
        .ev_uncor        (ev_uncor),
        .ev_uncor_masked (ev_uncor_masked),
        .ev_uncor_sev    (ev_uncor_sev),
        .ev_ur           (ev_ur),
        .ev_ur_uncor     (ev_ur_uncor),
        .ev_ur_sev       (ev_ur_sev),
        .msg_corr        (msg_corr),
        .msg_nonfatal    (msg_nonfatal),
        .msg_fatal       (msg_fatal),
        .flag_set        (flag_set),
        .sig_q           (sig_q)
    );

    always_comb begin
        stat_word                   = '0;
        stat_word[FLAG_LO +: NFLAG] = flag_q;
        stat_word[PEND_BIT]         = np_pending;
        acc_rdata = acc_hit ? (ctrl_q | stat_word) : '0;
    end

    assign sig_corr     = sig_q.cor;
    assign sig_nonfatal = sig_q.nf;
    assign sig_fatal    = sig_q.fat;
endmodule

// File: rtl/devctl_status_reg_chk.sv
module devctl_status_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_hit,
    input logic [3:0]  acc_be,
    input logic [31:0] acc_wdata,
    input logic [31:0] acc_rdata,
    input logic        root_port,
    input logic        ev_corr,
    input logic        ev_uncor,
    input logic        ev_ur,
    input logic        msg_corr,
    input logic        msg_nonfatal,
    input logic        msg_fatal,
    input logic [31:0] ctrl_q,
    input logic [3:0]  flag_q,
    input logic        sig_corr,
    input logic        sig_nonfatal,
    input logic        sig_fatal
);
    AST_ROOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !root_port |=> !(sig_corr || sig_nonfatal || sig_fatal)); // R11

    AST_COR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sig_corr |-> $past((ctrl_q[0] && (ev_corr || msg_corr)) || (ctrl_q[3] && ev_ur))); // R7

    AST_NF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sig_nonfatal |-> $past(ev_uncor || msg_nonfatal || ev_ur)); // R8

    AST_FAT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sig_fatal |-> $past(ev_uncor || msg_fatal || ev_ur)); // R9

    AST_COR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_corr |=> flag_q[0]); // R5

    AST_UR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ur |=> flag_q[3]); // R5

    for (genvar i = 0; i < 4; i++) begin : g_hold
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !(wr_hit && acc_be[2] && acc_wdata[16+i])) |=> flag_q[i]); // R6
    end

    AST_RO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rdata[31:22] == 10'd0) && !acc_rdata[20] && !acc_rdata[15] &&
        (acc_rdata[10:9] == 2'd0)); // R3
endmodule

bind devctl_status_reg devctl_status_reg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_hit       (wr_hit),
    .acc_be       (acc_be),
    .acc_wdata    (acc_wdata),
    .acc_rdata    (acc_rdata),
    .root_port    (root_port),
    .ev_corr      (ev_corr),
    .ev_uncor     (ev_uncor),
    .ev_ur        (ev_ur),
    .msg_corr     (msg_corr),
    .msg_nonfatal (msg_nonfatal),
    .msg_fatal    (msg_fatal),
    .ctrl_q       (ctrl_q),
    .flag_q       (flag_q),
    .sig_corr     (sig_corr),
    .sig_nonfatal (sig_nonfatal),
    .sig_fatal    (sig_fatal)
);

// File: tb/tb_devctl_status_reg.sv
`timescale 1ns/1ps
module tb_devctl_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] acc_addr = 12'h0C8;
    logic        acc_wr = 1'b0;
    logic [3:0]  acc_be = 4'h0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic root_port = 0, serr_en = 0, np_pending = 0;
    logic ev_corr = 0, ev_corr_masked = 0, ev_uncor = 0, ev_uncor_masked = 0;
    logic ev_uncor_sev = 0, ev_ur = 0, ev_ur_uncor = 0, ev_ur_sev = 0;
    logic msg_corr = 0, msg_nonfatal = 0, msg_fatal = 0;
    logic sig_corr, sig_nonfatal, sig_fatal;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    devctl_status_reg dut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
        .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .root_port(root_port), .serr_en(serr_en), .np_pending(np_pending),
        .ev_corr(ev_corr), .ev_corr_masked(ev_corr_masked), .ev_uncor(ev_uncor),
        .ev_uncor_masked(ev_uncor_masked), .ev_uncor_sev(ev_uncor_sev),
        .ev_ur(ev_ur), .ev_ur_uncor(ev_ur_uncor), .ev_ur_sev(ev_ur_sev),
        .msg_corr(msg_corr), .msg_nonfatal(msg_nonfatal), .msg_fatal(msg_fatal),
        .sig_corr(sig_corr), .sig_nonfatal(sig_nonfatal), .sig_fatal(sig_fatal)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        acc_addr = a; acc_wr = 1; acc_be = be; acc_wdata = d;
        @(negedge clk);
        acc_wr = 0; acc_be = 0; acc_addr = 12'h0C8;
    endtask

    task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        acc_addr = a;
        #1;
        check(acc_rdata, exp, tag);
        acc_addr = 12'h0C8;
    endtask

    task automatic clear_events();
        ev_corr = 0; ev_corr_masked = 0; ev_uncor = 0; ev_uncor_masked = 0;
        ev_uncor_sev = 0; ev_ur = 0; ev_ur_uncor = 0; ev_ur_sev = 0;
        msg_corr = 0; msg_nonfatal = 0; msg_fatal = 0;
    endtask

    // events were set at the previous negedge; one posedge registers them
    task automatic sig_check(input logic [2:0] exp, input string tag);
        @(negedge clk);
        clear_events();
        check({29'd0, sig_corr, sig_nonfatal, sig_fatal}, {29'd0, exp}, tag);
    endtask

    task automatic t_reset();
        rd_check(12'h0C8, 32'h0000_2910, "R1 reset value");
        check({29'd0, sig_corr, sig_nonfatal, sig_fatal}, 32'd0, "R11 outputs idle after reset");
    endtask

    task automatic t_rw();
        wr(12'h0C8, 4'hF, 32'hFFFF_FFFF);
        rd_check(12'h0C8, 32'h0000_79FF, "R2 R3 full write masks read-only bits");
        wr(12'h0C8, 4'h1, 32'h0000_0000);
        rd_check(12'h0C8, 32'h0000_7900, "R2 lane 0 only");
        wr(12'h0C4, 4'hF, 32'h0000_0000);
        rd_check(12'h0C8, 32'h0000_7900, "R2 other address write ignored");
        rd_check(12'h0C4, 32'h0000_0000, "R2 other address reads zero");
        wr(12'h0C8, 4'h2, 32'h0000_0000);
        rd_check(12'h0C8, 32'h0000_0000, "R2 lane 1 cleared");
    endtask

    task automatic t_pending();
        np_pending = 1;
        rd_check(12'h0C8, 32'h0020_0000, "R4 pending visible");
        np_pending = 0;
        rd_check(12'h0C8, 32'h0000_0000, "R4 pending dropped");
    endtask

    task automatic t_flags();
        @(negedge clk); msg_corr = 1; msg_nonfatal = 1; msg_fatal = 1;
        @(negedge clk); clear_events();
        rd_check(12'h0C8, 32'h0000_0000, "R5 messages set no flag");
        @(negedge clk); ev_corr = 1; ev_corr_masked = 1;
        @(negedge clk); clear_events();
        rd_check(12'h0C8, 32'h0001_0000, "R5 masked correctable sets bit16");
        @(negedge clk); ev_uncor = 1; ev_uncor_masked = 1;
        @(negedge clk); ev_uncor = 1; ev_uncor_sev = 1;
        @(negedge clk); clear_events(); ev_ur = 1; ev_ur_uncor = 1;
        @(negedge clk); clear_events();
        rd_check(12'h0C8, 32'h000F_0000, "R5 all four flags set");
        wr(12'h0C8, 4'h4, 32'h0005_0000);
        rd_check(12'h0C8, 32'h000A_0000, "R6 write one clears");
        wr(12'h0C8, 4'h3, 32'h000A_0000);
        rd_check(12'h0C8, 32'h000A_0000, "R6 lane 2 disabled no clear");
        // set and clear of bit16 in the same cycle
        @(negedge clk);
        acc_wr = 1; acc_be = 4'h4; acc_wdata = 32'h0001_0000; ev_corr = 1;
        @(negedge clk);
        acc_wr = 0; acc_be = 0; clear_events();
        rd_check(12'h0C8, 32'h000B_0000, "R6 set wins over clear");
        wr(12'h0C8, 4'h4, 32'h000F_0000);
        rd_check(12'h0C8, 32'h0000_0000, "R6 all flags cleared");
    endtask

    task automatic t_corr();
        root_port = 1;
        @(negedge clk); ev_corr = 1;
        sig_check(3'b000, "R7 no enable no output");
        wr(12'h0C8, 4'hF, 32'h0000_0001);
        @(negedge clk); ev_corr = 1; ev_corr_masked = 1;
        sig_check(3'b000, "R7 masked correctable silent");
        @(negedge clk); ev_corr = 1;
        sig_check(3'b100, "R7 unmasked correctable");
        check({31'd0, sig_corr}, 32'd1, "R11 pulse present");
        @(negedge clk);
        check({31'd0, sig_corr}, 32'd0, "R11 pulse is one cycle");
        @(negedge clk); msg_corr = 1;
        sig_check(3'b100, "R7 correctable message");
        root_port = 0;
        @(negedge clk); msg_corr = 1;
        sig_check(3'b000, "R11 not root port");
        root_port = 1;
        // enable written in the event's cycle: old value (1) gates
        @(negedge clk);
        acc_wr = 1; acc_be = 4'h1; acc_wdata = 0; msg_corr = 1;
        @(negedge clk);
        acc_wr = 0; acc_be = 0; clear_events();
        check({31'd0, sig_corr}, 32'd1, "R7 old enable used");
    endtask

    task automatic t_nf_fat();
        @(negedge clk); msg_nonfatal = 1;
        sig_check(3'b000, "R8 disabled");
        serr_en = 1;
        @(negedge clk); msg_nonfatal = 1;
        sig_check(3'b010, "R8 serr enables non-fatal");
        @(negedge clk); msg_fatal = 1;
        sig_check(3'b001, "R9 serr enables fatal");
        serr_en = 0;
        wr(12'h0C8, 4'hF, 32'h0000_0006);
        @(negedge clk); ev_uncor = 1;
        sig_check(3'b010, "R8 uncorrectable sev0");
        @(negedge clk); ev_uncor = 1; ev_uncor_masked = 1;
        sig_check(3'b000, "R8 masked uncorrectable silent");
        @(negedge clk); ev_uncor = 1; ev_uncor_sev = 1;
        sig_check(3'b001, "R9 uncorrectable sev1");
        @(negedge clk); msg_fatal = 1;
        sig_check(3'b001, "R9 fatal message");
        wr(12'h0C8, 4'hF, 32'h0000_0000);
        @(negedge clk); msg_fatal = 1;
        sig_check(3'b000, "R9 disabled");
    endtask

    task automatic t_ur();
        wr(12'h0C8, 4'hF, 32'h0000_0008);
        @(negedge clk); ev_ur = 1;
        sig_check(3'b100, "R10 correctable UR");
        @(negedge clk); ev_ur = 1; ev_ur_uncor = 1;
        sig_check(3'b010, "R10 uncorrectable UR sev0");
        @(negedge clk); ev_ur = 1; ev_ur_uncor = 1; ev_ur_sev = 1;
        sig_check(3'b001, "R10 uncorrectable UR sev1");
        wr(12'h0C8, 4'hF, 32'h0000_0000);
        @(negedge clk); ev_ur = 1; ev_ur_uncor = 1;
        sig_check(3'b000, "R10 UR disabled");
        serr_en = 1;
        @(negedge clk); ev_ur = 1; ev_ur_uncor = 1;
        sig_check(3'b001, "R10 serr routes UR to fatal");
        @(negedge clk); ev_ur = 1;
        sig_check(3'b000, "R10 serr ignores correctable UR");
        serr_en = 0;
        wr(12'h0C8, 4'h4, 32'h000F_0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_rw();
        t_pending();
        t_flags();
        t_corr();
        t_nf_fat();
        t_ur();
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule